// File: doc/BRIEF.md
# Serial flash command front end

This block is the slave-side protocol engine of a serial NOR flash device. A host selects the device by pulling the chip-select line low, then clocks an 8-bit opcode, optional address, dummy and data bytes in on the serial input, most significant bit first. The block decodes the command, tracks the write-enable latch, and turns each accepted command into a single-cycle request to a memory back end (read byte, program byte, erase sector, erase block, erase chip, write status). Read data and the status byte come back serially on the output pin, which is driven only while a read or status stream is active.

The serial pins are sampled by the core clock, so the SCK half period must span at least three core clock cycles. Write-type commands are committed only when chip-select returns high exactly on a byte boundary after the last required byte. A chip-select rise in the middle of a byte, or any extra bits after the last byte, drops the command. While the back end reports busy, only the status read is honoured.

Top module: `spi_flash_cmd_fe`

## Requirements
- R1: Bytes are 8 SCK periods long, shifted most significant bit first, with the serial input sampled on rising SCK while chip-select is low; the three address bytes form a 24-bit address, high byte first, of which the low ADDR_W bits are used.
- R2: Opcode 03h takes three address bytes and streams data from the next falling SCK; a read request (req_op = 0) is issued when the last address bit arrives and at every following byte boundary, with the address incrementing and wrapping at 2^ADDR_W.
- R3: Opcode 0Bh behaves like 03h but takes one dummy byte after the address; the first read request is issued at the end of the dummy byte.
- R4: Opcode 06h sets and opcode 04h clears the write-enable latch; the status byte is {back-end status bits 7:2, latch at bit 1, busy at bit 0}.
- R5: Program (02h), sector erase (20h), block erase (52h) and chip erase (60h or C7h) issue no request unless the write-enable latch is set.
- R6: An accepted program issues one request with req_op = 1, the received address and the data byte, one cycle long.
- R7: Sector erase issues req_op = 2 with address bits below SECT_BITS cleared; block erase issues req_op = 3 with bits below BLK_BITS cleared; chip erase issues req_op = 4 with address zero.
- R8: A chip-select rise before the last bit of a byte, or any SCK rise after the last required byte of a write-type command, drops the command with no request and no latch change.
- R9: Write status (01h) takes one data byte and issues req_op = 5 with that byte, when the write-enable latch is set or when the directly preceding command was 50h.
- R10: After a write-type request, the write-enable latch clears when the back end's busy flag falls.
- R11: While the back end is busy, every opcode except 05h is ignored; 05h repeats the live status byte for as long as SCK runs.
- R12: An unknown opcode causes no request and leaves the output undriven until chip-select rises.
- R13: The output enable is low after reset, while chip-select is high and outside read and status data phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, valid while so_oe is high |
| so_oe | output | 1 | Output driver enable for so |
| be_busy | input | 1 | Back end is executing a program, erase or status write |
| be_stat | input | 6 | Back-end status bits reported as status bits 7:2 |
| be_rdata | input | 8 | Read data, valid from the cycle after a read request |
| req_valid | output | 1 | Single-cycle request strobe |
| req_op | output | 3 | Request kind: 0 read, 1 program, 2 sector erase, 3 block erase, 4 chip erase, 5 status write |
| req_addr | output | ADDR_W | Byte address of the request |
| req_data | output | 8 | Program or status data |

## Verification
The bench builds the block with ADDR_W = 16, which keeps both erase masks inside the address and lets a short fast read cross from the top of the space back to address zero, while the 24-bit address bytes still carry upper bits that must be dropped. A back-end model with a long busy window makes status reads, latch clearing and ignored commands observable while a write is in flight, and the read data is a function of the address so every streamed byte can be predicted.

// File: rtl/spi_flash_cmd_fe.sv
module spi_flash_cmd_fe #(
  parameter int ADDR_W    = 19,
  parameter int SECT_BITS = 12,
  parameter int BLK_BITS  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic              be_busy,
  input  logic [5:0]        be_stat,
  input  logic [7:0]        be_rdata,
  output logic              req_valid,
  output logic [2:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data
);
  localparam logic [7:0] OP_READ        = 8'h03;
  localparam logic [7:0] OP_FREAD       = 8'h0B;
  localparam logic [7:0] OP_PROG        = 8'h02;
  localparam logic [7:0] OP_SERASE      = 8'h20;
  localparam logic [7:0] OP_BERASE      = 8'h52;
  localparam logic [7:0] OP_CERASE_A    = 8'h60;
  localparam logic [7:0] OP_CERASE_B    = 8'hC7;
  localparam logic [7:0] OP_STAT_WR     = 8'h01;
  localparam logic [7:0] OP_STAT_RD     = 8'h05;
  localparam logic [7:0] OP_WR_EN       = 8'h06;
  localparam logic [7:0] OP_WR_DIS      = 8'h04;
  localparam logic [7:0] OP_STAT_UNLOCK = 8'h50;

  localparam logic [2:0] RQ_READ = 3'd0;
  localparam logic [2:0] RQ_PROG = 3'd1;
  localparam logic [2:0] RQ_SECT = 3'd2;
  localparam logic [2:0] RQ_BLK  = 3'd3;
  localparam logic [2:0] RQ_CHIP = 3'd4;
  localparam logic [2:0] RQ_STAT = 3'd5;

  localparam logic [ADDR_W-1:0] SECT_KEEP = {ADDR_W{1'b1}} << SECT_BITS;
  localparam logic [ADDR_W-1:0] BLK_KEEP  = {ADDR_W{1'b1}} << BLK_BITS;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_DUMMY, ST_RDATA, ST_STAT, ST_WDATA, ST_DONE, ST_SKIP
  } st_t;

  st_t         st, op_st;
  logic        s_sck, p_sck, s_cs, p_cs, s_si;
  logic [2:0]  bitc;
  logic [1:0]  bytec;
  logic [7:0]  rx, op, wdat, tx;
  logic [23:0] addr;
  logic        wel, ews, pend_clr, busy_q, load;
  logic        wr_go;
  logic [2:0]  wr_kind;
  logic [ADDR_W-1:0] wr_addr;

  wire sck_rise = s_sck & ~p_sck & ~s_cs;
  wire sck_fall = ~s_sck & p_sck & ~s_cs;
  wire cs_rise  = s_cs & ~p_cs;
  wire byte_end = sck_rise && (bitc == 3'd7);

  wire [7:0]  rx_nxt    = {rx[6:0], s_si};
  wire [23:0] addr_nxt  = {addr[22:0], s_si};
  wire [7:0]  stat_byte = {be_stat, wel, be_busy};

  wire rd_go = byte_end && ((st == ST_ADDR && bytec == 2'd2 && op == OP_READ) ||
                            st == ST_DUMMY || st == ST_RDATA);
  wire [23:0] rd_addr = (st == ST_ADDR) ? addr_nxt : addr;

  assign so = tx[7];

  always_comb begin
    op_st = ST_SKIP;
    if (!be_busy || rx_nxt == OP_STAT_RD) begin
      case (rx_nxt)
        OP_READ, OP_FREAD:              op_st = ST_ADDR;
        OP_PROG, OP_SERASE, OP_BERASE:  if (wel) op_st = ST_ADDR;
        OP_CERASE_A, OP_CERASE_B:       if (wel) op_st = ST_DONE;
        OP_STAT_WR:                     if (wel || ews) op_st = ST_WDATA;
        OP_WR_EN, OP_WR_DIS, OP_STAT_UNLOCK: op_st = ST_DONE;
        OP_STAT_RD:                     op_st = ST_STAT;
        default:                        op_st = ST_SKIP;
      endcase
    end
  end

  always_comb begin
    wr_go   = 1'b1;
    wr_kind = RQ_PROG;
    wr_addr = addr[ADDR_W-1:0];
    case (op)
      OP_PROG: ;
      OP_SERASE: begin
        wr_kind = RQ_SECT;
        wr_addr = addr[ADDR_W-1:0] & SECT_KEEP;
      end
      OP_BERASE: begin
        wr_kind = RQ_BLK;
        wr_addr = addr[ADDR_W-1:0] & BLK_KEEP;
      end
      OP_CERASE_A, OP_CERASE_B: begin
        wr_kind = RQ_CHIP;
        wr_addr = '0;
      end
      OP_STAT_WR: begin
        wr_kind = RQ_STAT;
        wr_addr = '0;
      end
      default: wr_go = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sck     <= 1'b0;
      p_sck     <= 1'b0;
      s_cs      <= 1'b1;
      p_cs      <= 1'b1;
      s_si      <= 1'b0;
      busy_q    <= 1'b0;
      st        <= ST_OPC;
      bitc      <= '0;
      bytec     <= '0;
      rx        <= '0;
      op        <= '0;
      wdat      <= '0;
      tx        <= '1;
      addr      <= '0;
      wel       <= 1'b0;
      ews       <= 1'b0;
      pend_clr  <= 1'b0;
      load      <= 1'b0;
      so_oe     <= 1'b0;
      req_valid <= 1'b0;
      req_op    <= RQ_READ;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      s_sck     <= sck;
      p_sck     <= s_sck;
      s_cs      <= cs_n;
      p_cs      <= s_cs;
      s_si      <= si;
      busy_q    <= be_busy;
      req_valid <= 1'b0;

      if (pend_clr && busy_q && !be_busy) begin
        wel      <= 1'b0;
        pend_clr <= 1'b0;
      end

      if (sck_rise) begin
        rx   <= rx_nxt;
        bitc <= bitc + 3'd1;
        case (st)
          ST_OPC: if (byte_end) begin
            op    <= rx_nxt;
            st    <= op_st;
            ews   <= 1'b0;
            bytec <= '0;
            if (op_st == ST_STAT) load <= 1'b1;
          end
          ST_ADDR: begin
            addr <= addr_nxt;
            if (byte_end) begin
              bytec <= bytec + 2'd1;
              if (bytec == 2'd2) begin
                if (op == OP_READ)       st <= ST_RDATA;
                else if (op == OP_FREAD) st <= ST_DUMMY;
                else if (op == OP_PROG)  st <= ST_WDATA;
                else                     st <= ST_DONE;
              end
            end
          end
          ST_DUMMY: if (byte_end) st <= ST_RDATA;
          ST_STAT:  if (byte_end) load <= 1'b1;
          ST_WDATA: if (byte_end) begin
            wdat <= rx_nxt;
            st   <= ST_DONE;
          end
          ST_DONE:  st <= ST_SKIP;
          default: ;
        endcase
        if (rd_go) begin
          req_valid <= 1'b1;
          req_op    <= RQ_READ;
          req_addr  <= rd_addr[ADDR_W-1:0];
          req_data  <= '0;
          addr      <= rd_addr + 24'd1;
          load      <= 1'b1;
        end
      end

      if (sck_fall) begin
        if (load) begin
          tx    <= (st == ST_STAT) ? stat_byte : be_rdata;
          load  <= 1'b0;
          so_oe <= 1'b1;
        end else begin
          tx <= {tx[6:0], 1'b1};
        end
      end

      if (cs_rise && st == ST_DONE) begin
        if (op == OP_WR_EN)       wel <= 1'b1;
        if (op == OP_WR_DIS)      wel <= 1'b0;
        if (op == OP_STAT_UNLOCK) ews <= 1'b1;
        if (wr_go) begin
          req_valid <= 1'b1;
          req_op    <= wr_kind;
          req_addr  <= wr_addr;
          req_data  <= wdat;
          pend_clr  <= 1'b1;
        end
      end

      if (s_cs) begin
        st    <= ST_OPC;
        bitc  <= '0;
        bytec <= '0;
        load  <= 1'b0;
        so_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_flash_cmd_fe_chk.sv
module spi_flash_cmd_fe_chk #(
  parameter int ADDR_W    = 19,
  parameter int SECT_BITS = 12,
  parameter int BLK_BITS  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              so_oe,
  input logic              be_busy,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] req_addr
);
  localparam logic [ADDR_W-1:0] SECT_LOW = ~({ADDR_W{1'b1}} << SECT_BITS);
  localparam logic [ADDR_W-1:0] BLK_LOW  = ~({ADDR_W{1'b1}} << BLK_BITS);

  a_r13_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |=> !so_oe);

  a_r11_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    be_busy |-> !req_valid);

  a_r6_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  a_r8_write_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 3'd0) |-> $past(cs_n, 2));

  a_r2_read_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd0) |-> !$past(cs_n, 2));

  a_r7_sector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2) |-> ((req_addr & SECT_LOW) == '0));

  a_r7_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd3) |-> ((req_addr & BLK_LOW) == '0));

  a_r7_chip_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4) |-> (req_addr == '0));
endmodule

bind spi_flash_cmd_fe spi_flash_cmd_fe_chk #(
  .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .BLK_BITS(BLK_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe), .be_busy(be_busy),
  .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr)
);

// File: tb/spi_flash_cmd_fe_tb.sv
`timescale 1ns/1ps
module spi_flash_cmd_fe_tb;
  localparam int AW   = 16;
  localparam int BUSY = 1500;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe, be_busy, req_valid;
  logic [5:0] be_stat = '0;
  logic [7:0] be_rdata = '0;
  logic [2:0] req_op;
  logic [AW-1:0] req_addr;
  logic [7:0] req_data;
  int bcnt = 0;

  always #2.5 clk = ~clk;

  spi_flash_cmd_fe #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
    .be_busy(be_busy), .be_stat(be_stat), .be_rdata(be_rdata), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data)
  );

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // back-end model
  assign be_busy = (bcnt != 0);
  always @(posedge clk) begin
    if (req_valid && req_op == 3'd0) be_rdata <= mem_f(req_addr);
    if (req_valid && req_op != 3'd0) bcnt <= BUSY;
    else if (bcnt > 0) bcnt <= bcnt - 1;
    if (req_valid && req_op == 3'd5) be_stat <= req_data[7:2];
  end

  typedef struct {
    logic [2:0]  op;
    logic [15:0] addr;
    logic [7:0]  data;
    string       tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  int n_chk = 0, n_fail = 0, cs_hi = 0;
  bit finished = 0, any_oe = 0;
  logic wel_m = 0;
  logic [5:0] stat_m = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] op, input logic [15:0] a, input logic [7:0] d, input string tag);
    exp_t x;
    x.op = op; x.addr = a; x.data = d; x.tag = tag;
    q.push_back(x);
  endtask

  // per-clock comparison against the expected request stream
  always @(negedge clk) begin
    if (rst_n) begin
      cs_hi = cs_n ? cs_hi + 1 : 0;
      if (cs_hi > 3) chk(!so_oe, "R13 output enable while deselected", 32'(so_oe), 0);
      if (req_valid) begin
        if (q.size() == 0)
          chk(0, "R5 R8 R11 R12 unexpected request", {req_op, req_addr, req_data}, 0);
        else begin
          e = q.pop_front();
          chk(req_op == e.op && req_addr == e.addr &&
              (!(e.op == 3'd1 || e.op == 3'd5) || req_data == e.data),
              e.tag, {req_op, req_addr, req_data}, {e.op, e.addr, e.data});
        end
      end
    end
  end

  task automatic xbits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      si = b[i];
      repeat (4) @(negedge clk);
      sck = 1'b1;
      r[i] = so;
      if (so_oe) any_oe = 1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    xbits(b, 8, r);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] r;
    xbyte(a[23:16], r);
    xbyte(a[15:8], r);
    xbyte(a[7:0], r);
  endtask

  task automatic cmd1(input logic [7:0] o);
    logic [7:0] r;
    sel();
    xbyte(o, r);
    desel();
  endtask

  task automatic wait_idle();
    while (be_busy) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic q_empty(input string tag);
    chk(q.size() == 0, tag, q.size(), 0);
    q.delete();
  endtask

  task automatic stat_rd(input int n, input logic [7:0] exp, input string tag);
    logic [7:0] r;
    sel();
    xbyte(8'h05, r);
    for (int i = 0; i < n; i++) begin
      xbyte(8'hFF, r);
      chk(r == exp, tag, r, exp);
    end
    desel();
  endtask

  task automatic rd(input logic [7:0] o, input logic [23:0] a, input int n, input string tag);
    logic [7:0] r;
    logic [15:0] ai;
    for (int i = 0; i <= n; i++) push(3'd0, a[15:0] + 16'(i), 8'h00, tag);
    sel();
    xbyte(o, r);
    send_addr(a);
    if (o == 8'h0B) xbyte(8'h00, r);
    for (int i = 0; i < n; i++) begin
      xbyte(8'hFF, r);
      ai = a[15:0] + 16'(i);
      chk(r == mem_f(ai), tag, r, mem_f(ai));
    end
    desel();
    q_empty(tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!so_oe && !req_valid, "R13 reset state", {so_oe, req_valid}, 0);
    stat_rd(1, 8'h00, "R4 status after reset");

    // latch set and clear
    cmd1(8'h06);
    stat_rd(1, 8'h02, "R4 latch set");
    cmd1(8'h04);
    stat_rd(1, 8'h00, "R4 latch cleared");

    // abort inside the opcode byte
    sel(); xbits(8'h06, 7, r); desel();
    stat_rd(1, 8'h00, "R8 partial opcode dropped");

    // write commands without the latch
    sel(); xbyte(8'h02, r); send_addr(24'h000100); xbyte(8'h55, r); desel();
    sel(); xbyte(8'h20, r); send_addr(24'h001000); desel();
    sel(); xbyte(8'hC7, r); desel();
    sel(); xbyte(8'h01, r); xbyte(8'hFC, r); desel();
    q_empty("R5 no request without latch");
    stat_rd(1, 8'h00, "R5 idle after refused writes");

    // reads
    rd(8'h03, 24'h000102, 1, "R1 address byte order");
    rd(8'h03, 24'h051234, 4, "R2 read stream");
    rd(8'h0B, 24'hABFFFE, 3, "R3 fast read with wrap");

    // program, then status during busy
    cmd1(8'h06);
    push(3'd1, 16'h0456, 8'h3C, "R6 program request");
    sel(); xbyte(8'h02, r); send_addr(24'h770456); xbyte(8'h3C, r); desel();
    q_empty("R6 program request issued");
    stat_rd(3, 8'h03, "R11 repeated status while busy");
    any_oe = 0;
    sel(); xbyte(8'h03, r); send_addr(24'h000010); xbyte(8'hFF, r); desel();
    chk(!any_oe, "R11 read ignored while busy", any_oe, 0);
    q_empty("R11 no request while busy");
    chk(be_busy, "R10 latch held during busy", be_busy, 1);
    wait_idle();
    stat_rd(1, 8'h00, "R10 latch cleared after busy");

    // erases
    cmd1(8'h06);
    push(3'd2, 16'h3000, 8'h00, "R7 sector erase");
    sel(); xbyte(8'h20, r); send_addr(24'h123ABC); desel();
    wait_idle();
    cmd1(8'h06);
    push(3'd3, 16'h8000, 8'h00, "R7 block erase");
    sel(); xbyte(8'h52, r); send_addr(24'h00FEDC); desel();
    wait_idle();
    cmd1(8'h06);
    push(3'd4, 16'h0000, 8'h00, "R7 chip erase C7h");
    cmd1(8'hC7);
    wait_idle();
    cmd1(8'h06);
    push(3'd4, 16'h0000, 8'h00, "R7 chip erase 60h");
    cmd1(8'h60);
    wait_idle();
    q_empty("R7 erase requests issued");
    stat_rd(1, 8'h00, "R10 latch cleared after erases");

    // aborted programs
    cmd1(8'h06);
    sel(); xbyte(8'h02, r); send_addr(24'h000200); xbits(8'hAA, 5, r); desel();
    sel(); xbyte(8'h02, r); send_addr(24'h000200); xbyte(8'hAA, r); xbits(8'h00, 3, r); desel();
    q_empty("R8 aborted programs");
    stat_rd(1, 8'h02, "R8 latch kept after abort");
    cmd1(8'h04);

    // status writes
    cmd1(8'h06);
    push(3'd5, 16'h0000, 8'hA4, "R9 status write via latch");
    sel(); xbyte(8'h01, r); xbyte(8'hA4, r); desel();
    wait_idle();
    stat_rd(1, 8'hA4, "R9 R4 status bits after write");
    cmd1(8'h50);
    push(3'd5, 16'h0000, 8'h58, "R9 status write via unlock");
    sel(); xbyte(8'h01, r); xbyte(8'h58, r); desel();
    wait_idle();
    stat_rd(1, 8'h58, "R9 status after unlock write");
    cmd1(8'h50);
    cmd1(8'h04);
    sel(); xbyte(8'h01, r); xbyte(8'h10, r); desel();
    q_empty("R9 unlock applies to next command only");
    stat_rd(1, 8'h58, "R9 status unchanged");

    // unknown opcode
    any_oe = 0;
    sel(); xbyte(8'h9F, r); xbyte(8'hFF, r); xbyte(8'hFF, r); xbyte(8'hFF, r); desel();
    chk(!any_oe, "R12 unknown opcode leaves output off", any_oe, 0);
    q_empty("R12 unknown opcode no request");

    finish_run();
  end
endmodule